// File: doc/BRIEF.md
# Multi-channel down-counting timer

A memory-mapped timer with two or four independent channels (set by a parameter). Each channel holds a 64-bit interval and a 64-bit current count, both reachable as a low and a high 32-bit word. When a channel is enabled, its count decreases once per counting tick. A per-channel prescaler can lengthen the time between ticks. When the count reaches zero, the channel raises its pending flag. In periodic mode the channel then reloads and keeps going. In one-shot mode it switches itself off and stays at zero.

The pending flags share one status register and the interrupt masks share one enable register. Together they drive a single interrupt line. A host reads and writes the registers over a single-cycle bus: a read returns data combinationally in the cycle it is presented, and a write takes effect at the next clock edge. Software that wants an elapsed-time value inverts the count, because the count runs downward. A channel loaded with an all-ones low interval word runs as a 32-bit wrap-around time base.

Top module: `hs_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map. Enable mask is at 0x00 and status at 0x04, with bit n belonging to channel n. For channel n: control at 0x20n+0x10, interval low/high at 0x20n+0x14 / 0x20n+0x18, count low/high at 0x20n+0x1C / 0x20n+0x20. Control fields: bit 0 enable, bit 1 reload request, bits 6:4 prescaler select, bit 7 one-shot (1) or periodic (0). Control bits 3:2 and 31:8 read zero. Interval words read back what was written.
- R3: A reload request copies the full 64-bit interval into the count on the channel's next counting tick, and the reload bit then reads zero.
- R4: On each tick of a running channel, a nonzero count decreases by one. A tick at zero sets the channel's status bit. In periodic mode that tick also reloads the interval, so the inverted count grows by one per tick.
- R5: In one-shot mode, a tick at zero sets the status bit, clears the enable bit and leaves the count at zero.
- R6: Prescaler select p gives one tick every 2^p clock cycles. The first tick comes 2^p cycles after the enable takes effect.
- R7: A write that clears the enable bit of an enabled channel lets it run for exactly two further clock cycles. After that the count holds.
- R8: `irq` is high exactly when some channel has both its status bit and its enable-mask bit set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new event occurs in the same cycle as the clear, the bit stays set.
- R10: Reads of unmapped offsets, of misaligned addresses and of channels at or above NUM_CH return zero. Writes to them, and to the count words, change nothing.
- R11: The count is 64 bits wide. Decrementing the count carries correctly from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- status bits are never lost except through a clear written by the host;
- the interrupt stays low while all masks are off;
- an idle channel's count never moves;
- a running count only holds or steps down by one;
- an enable bit falls without a host write only at zero in one-shot mode;
- unmapped reads return zero.

Only the bench scenarios show the cycle-exact parts:
- the two-cycle run-on after a disable;
- when the first tick arrives under the prescaler;
- the reload taking effect on the first tick;
- the carry from the low count word into the high word;
- the clear-versus-event collision;
- that writes to absent channels and to count words leave state untouched.

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 8,
  parameter int SYNC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int DW   = 32;
  localparam int CW   = 64;
  localparam int PW   = 3;
  localparam int DIVW = (1 << PW) - 1;
  localparam int SW   = $clog2(SYNC_CYC + 1);
  localparam int IW   = ADDR_W - 5;
  localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CH0 = ADDR_W'(16);

  logic [NUM_CH-1:0] ie, sts, evt, clr, en, rel, os;
  logic [NUM_CH-1:0][SW-1:0] stopc;
  logic [NUM_CH-1:0][CW-1:0] cnt;
  logic [NUM_CH-1:0][DW-1:0] rd_ch;

  wire wr_en  = bus_sel & bus_wr;
  wire in_win = (bus_addr >= A_CH0) && (bus_addr[1:0] == 2'b00);
  wire [ADDR_W-3:0] woff = bus_addr[ADDR_W-1:2] - (ADDR_W-2)'(4);
  wire [2:0] sub = woff[2:0];
  wire [IW-1:0] ch_sel = woff[ADDR_W-3:3];

  assign clr = (wr_en && bus_addr == A_ST) ? bus_wdata[NUM_CH-1:0] : '0;
  assign irq = |(sts & ie);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic            en_r, rel_r, os_r;
    logic [PW-1:0]   pre_r;
    logic [SW-1:0]   stop_r;
    logic [DIVW-1:0] pc_r;
    logic [CW-1:0]   iv_r, cn_r;

    wire sel_ch = in_win && (ch_sel == IW'(n));
    wire w_ctl  = wr_en && sel_ch && sub == 3'd0;
    wire w_ilo  = wr_en && sel_ch && sub == 3'd1;
    wire w_ihi  = wr_en && sel_ch && sub == 3'd2;
    wire run    = en[n] | (stopc[n] != '0);
    wire [DIVW-1:0] mask = ~({DIVW{1'b1}} << pre_r);
    wire tick   = run && ((pc_r & mask) == mask);

    assign en[n]    = en_r;
    assign rel[n]   = rel_r;
    assign os[n]    = os_r;
    assign stopc[n] = stop_r;
    assign cnt[n]   = cn_r;
    assign evt[n]   = tick && !rel[n] && (cnt[n] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        rel_r  <= 1'b0;
        os_r   <= 1'b0;
        pre_r  <= '0;
        stop_r <= '0;
        pc_r   <= '0;
        iv_r   <= '0;
        cn_r   <= '0;
      end else begin
        pc_r <= run ? pc_r + 1'b1 : '0;
        if (stop_r != '0) stop_r <= stop_r - 1'b1;
        if (tick) begin
          if (rel_r) begin
            cn_r  <= iv_r;
            rel_r <= 1'b0;
          end else if (cn_r == '0) begin
            if (os_r) en_r <= 1'b0;
            else      cn_r <= iv_r;
          end else begin
            cn_r <= cn_r - 1'b1;
          end
        end
        if (w_ctl) begin
          en_r  <= bus_wdata[0];
          rel_r <= bus_wdata[1];
          pre_r <= bus_wdata[PW+3:4];
          os_r  <= bus_wdata[7];
          if (en_r && !bus_wdata[0]) stop_r <= SW'(SYNC_CYC);
        end
        if (w_ilo) iv_r[DW-1:0]  <= bus_wdata;
        if (w_ihi) iv_r[CW-1:DW] <= bus_wdata;
      end
    end

    always_comb begin
      rd_ch[n] = '0;
      if (sel_ch) begin
        case (sub)
          3'd0:    rd_ch[n] = {24'b0, os[n], pre_r, 2'b00, rel[n], en[n]};
          3'd1:    rd_ch[n] = iv_r[DW-1:0];
          3'd2:    rd_ch[n] = iv_r[CW-1:DW];
          3'd3:    rd_ch[n] = cnt[n][DW-1:0];
          3'd4:    rd_ch[n] = cnt[n][CW-1:DW];
          default: rd_ch[n] = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie  <= '0;
      sts <= '0;
    end else begin
      sts <= (sts & ~clr) | evt;
      if (wr_en && bus_addr == A_IE) ie <= bus_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_IE)      bus_rdata = DW'(ie);
      else if (bus_addr == A_ST) bus_rdata = DW'(sts);
      else
        for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | rd_ch[i];
    end
  end
endmodule

// File: rtl/hs_timer_chk.sv
module hs_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int SW     = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [31:0]                  bus_rdata,
  input logic                         irq,
  input logic [NUM_CH-1:0]            ie,
  input logic [NUM_CH-1:0]            sts,
  input logic [NUM_CH-1:0]            clr,
  input logic [NUM_CH-1:0]            en,
  input logic [NUM_CH-1:0]            rel,
  input logic [NUM_CH-1:0]            os,
  input logic [NUM_CH-1:0][SW-1:0]    stopc,
  input logic [NUM_CH-1:0][63:0]      cnt
);
  // R9
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts) & ~$past(clr)) & ~sts) == '0));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr[1:0] != 2'b00 || bus_addr == ADDR_W'(8) ||
     bus_addr == ADDR_W'(12))) |-> (bus_rdata == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(32 * n + 16);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[n] && stopc[n] == '0) |=> $stable(cnt[n]));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[n] && !rel[n] && cnt[n] != '0) |=>
      (cnt[n] == $past(cnt[n]) || cnt[n] == $past(cnt[n]) - 64'd1));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en[n]) && !$past(bus_sel && bus_wr && bus_addr == CA)) |->
      ($past(os[n]) && cnt[n] == '0));
  end
endmodule

bind hs_timer hs_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .ie(ie),
  .sts(sts), .clr(clr), .en(en), .rel(rel), .os(os), .stopc(stopc), .cnt(cnt)
);

// File: tb/hs_timer_test.sv
module hs_timer_test;
  localparam int CLK_T = 10;
  localparam int NC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  hs_timer #(.NUM_CH(NC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference model
  bit m_en[NC], m_rel[NC], m_os[NC];
  int m_pre[NC], m_stop[NC], m_pc[NC];
  logic [63:0] m_iv[NC], m_cn[NC];
  logic [NC-1:0] m_ie = '0, m_sts = '0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int w, ch, sb;
    if (a == 8'h00) return 32'(m_ie);
    if (a == 8'h04) return 32'(m_sts);
    if (a < 8'h10 || a % 4 != 0) return 0;
    w = (int'(a) - 16) / 4;
    ch = w / 8;
    sb = w % 8;
    if (ch >= NC) return 0;
    case (sb)
      0: return {24'd0, m_os[ch], 3'(m_pre[ch]), 2'b00, m_rel[ch], m_en[ch]};
      1: return m_iv[ch][31:0];
      2: return m_iv[ch][63:32];
      3: return m_cn[ch][31:0];
      4: return m_cn[ch][63:32];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = '0;
      m_sts = '0;
      for (int c = 0; c < NC; c++) begin
        m_en[c] = 0; m_rel[c] = 0; m_os[c] = 0;
        m_pre[c] = 0; m_stop[c] = 0; m_pc[c] = 0;
        m_iv[c] = '0; m_cn[c] = '0;
      end
    end else begin
      logic [NC-1:0] ev, cl;
      bit wv;
      ev = '0;
      wv = bus_sel && bus_wr;
      cl = (wv && bus_addr == 8'h04) ? bus_wdata[NC-1:0] : '0;
      for (int c = 0; c < NC; c++) begin
        bit run, tick, old_en;
        int mask;
        old_en = m_en[c];
        run = m_en[c] || m_stop[c] > 0;
        mask = (1 << m_pre[c]) - 1;
        tick = run && ((m_pc[c] & mask) == mask);
        m_pc[c] = run ? (m_pc[c] + 1) % 128 : 0;
        if (m_stop[c] > 0) m_stop[c]--;
        if (tick) begin
          if (m_rel[c]) begin m_cn[c] = m_iv[c]; m_rel[c] = 0; end
          else if (m_cn[c] == 0) begin
            ev[c] = 1'b1;
            if (m_os[c]) m_en[c] = 0; else m_cn[c] = m_iv[c];
          end else m_cn[c] = m_cn[c] - 1;
        end
        if (wv && bus_addr == 8'(32*c + 16)) begin
          m_en[c] = bus_wdata[0];
          m_rel[c] = bus_wdata[1];
          m_pre[c] = int'(bus_wdata[6:4]);
          m_os[c] = bus_wdata[7];
          if (old_en && !bus_wdata[0]) m_stop[c] = 2;
        end
        if (wv && bus_addr == 8'(32*c + 20)) m_iv[c][31:0] = bus_wdata;
        if (wv && bus_addr == 8'(32*c + 24)) m_iv[c][63:32] = bus_wdata;
      end
      m_sts = (m_sts & ~cl) | ev;
      if (wv && bus_addr == 8'h00) m_ie = bus_wdata[NC-1:0];
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq vs model", 64'(irq), 64'((m_sts & m_ie) != 0));
      if (bus_sel && !bus_wr) chk("R2 read vs model", 64'(bus_rdata), 64'(m_read(bus_addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h00, v); chk("R1 ie", v, 0);
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h10, v); chk("R1 ctrl0", v, 0);
    rd(8'h3C, v); chk("R1 cnt1 lo", v, 0);
    chk("R1 irq", irq, 0);

    // R2 map and readback
    wr(8'h14, 32'd5); wr(8'h18, 32'd7);
    rd(8'h14, v); chk("R2 ival lo", v, 5);
    rd(8'h18, v); chk("R2 ival hi", v, 7);
    wr(8'h10, 32'hBC);
    rd(8'h10, v); chk("R2 ctrl fields", v, 32'hB0);
    wr(8'h10, 32'h0);

    // R3 reload, R4 periodic
    wr(8'h14, 32'd3); wr(8'h18, 32'd0); wr(8'h00, 32'd1);
    wr(8'h10, 32'h3);
    rd(8'h10, v); chk("R3 reload pending", v, 32'h3);
    rd(8'h10, v); chk("R3 reload self-clear", v, 32'h1);
    idle(12);
    rd(8'h04, v); chk("R4 periodic event", v & 1, 1);
    chk("R8 irq with mask", irq, 1);

    // R8 masking
    wr(8'h00, 32'd0);
    @(negedge clk); chk("R8 irq masked", irq, 0);
    @(posedge clk); #1;
    wr(8'h00, 32'd1);

    // R9 collision then clear
    wr(8'h14, 32'd0); wr(8'h10, 32'h3);
    idle(3);
    wr(8'h04, 32'd1);
    rd(8'h04, v); chk("R9 event wins over clear", v & 1, 1);
    wr(8'h10, 32'h0);
    idle(6);
    wr(8'h04, 32'd1);
    rd(8'h04, v); chk("R9 write-one clear", v, 0);

    // R5 one-shot
    wr(8'h34, 32'd4); wr(8'h38, 32'd0); wr(8'h30, 32'h83);
    idle(10);
    rd(8'h30, v); chk("R5 enable cleared", v, 32'h80);
    rd(8'h3C, v); chk("R5 count at zero", v, 0);
    rd(8'h04, v); chk("R5 status set", v, 2);

    // R6 prescaler p=2: event on the 16th cycle
    wr(8'h04, 32'd2); wr(8'h34, 32'd2);
    wr(8'h30, 32'hA3);
    idle(8);
    rd(8'h04, v); chk("R6 no event yet", v & 2, 0);
    idle(10);
    rd(8'h04, v); chk("R6 event after 16 cycles", v & 2, 2);

    // R7 disable run-on of two cycles
    wr(8'h14, 32'h100); wr(8'h10, 32'h3);
    idle(10);
    rd(8'h1C, v);
    wr(8'h10, 32'h0);
    idle(5);
    rd(8'h1C, v2); chk("R7 two extra cycles", v2, v - 4);
    idle(3);
    rd(8'h1C, v); chk("R7 count holds", v, v2);

    // R10 unmapped and absent
    rd(8'h08, v); chk("R10 unmapped", v, 0);
    wr(8'h1C, 32'h1234);
    rd(8'h1C, v); chk("R10 count write ignored", v, v2);
    rd(8'h50, v); chk("R10 absent ch", v, 0);
    wr(8'h50, 32'hFF);
    rd(8'h50, v); chk("R10 absent write", v, 0);
    rd(8'h11, v); chk("R10 misaligned", v, 0);
    rd(8'h10, v); chk("R10 ch0 untouched", v, 0);

    // R11 carry across words
    wr(8'h34, 32'd2); wr(8'h38, 32'd1); wr(8'h30, 32'h3);
    idle(3);
    rd(8'h40, v); chk("R11 hi before borrow", v, 1);
    rd(8'h3C, v); chk("R11 lo after borrow", v, 32'hFFFFFFFF);
    rd(8'h40, v); chk("R11 hi after borrow", v, 0);

    // R4 elapsed time by inversion
    wr(8'h34, 32'hFFFFFFFF); wr(8'h38, 32'd0); wr(8'h30, 32'h3);
    idle(3);
    rd(8'h3C, a);
    idle(4);
    rd(8'h3C, b);
    chk("R4 elapsed", 64'((~b) - (~a)), 5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule